// File: doc/BRIEF.md
# Timestamp Counter with Selectable Timebase

This block keeps a free-running timestamp for a host. A count register holds the elapsed time, and its unit is picked through a configuration register. The block runs from a 50 MHz system clock. Three timebases are available:

- **Nanoseconds.** The count grows by 20 on every clock, so the value is in true nanoseconds with 20 ns resolution.
- **Microseconds.** The count grows by one every 50 clocks.
- **Milliseconds.** The count grows by one every 50,000 clocks.

The count wraps silently at its full width.

The host reaches both registers through a plain register port: a write strobe, an address, write data, and combinational read data.

- **Configuration register.** An eight-bit selector picks the timebase. A level bit clears the count and holds it at zero for as long as the bit stays set. The usual reset sequence is two writes: first the current selector with the clear bit set, then the selector alone. The timebase is therefore kept across a reset.
- **Invalid selector.** A selector value above 2 freezes the count.
- **Prescaler restart.** A change of selector restarts the internal prescaler, so the first tick in the new unit takes a full period.

Top module: `tsc_timestamp`

## Requirements
- R1: While reset is asserted and immediately after it, the count reads 0 and the configuration reads 0 (nanosecond timebase, clear bit low).
- R2: A write to offset 0x600 loads the timebase selector from wdata bits 7:0 and the clear bit from wdata bit 8. A read of offset 0x600 returns the selector in bits 7:0, the clear bit in bit 8, and zeros above.
- R3: A read of offset 0x602 returns the count, zero-extended to 32 bits. A read of any other offset returns 0. A write to 0x602 changes neither the count nor the configuration.
- R4: With selector 0 and clear low, the count grows by 20 on every clock edge.
- R5: With selector 1 and clear low, the count grows by 1 once every 50 clock edges.
- R6: With selector 2 and clear low, the count grows by 1 once every 50,000 clock edges.
- R7: With a selector value above 2, the count holds its value.
- R8: A write that changes the selector restarts the prescaler, so the first increment in the new timebase comes a full period after the write edge.
- R9: While the clear bit is set, the count is held at 0 and the selector is kept. After the clear bit is released, the first increment comes a full period of the selected timebase later.
- R10: The count wraps modulo 2^CNT_W with no indication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (12) | Register offset |
| wdata | input | 16 | Write data for the configuration register |
| rdata | output | DATA_W (32) | Read data for the addressed register |

## Verification
Some behaviours are checked by assertions on every cycle:
- the per-edge step in each timebase (exactly 20, or 0 or 1);
- the frozen count under an invalid selector;
- the zero count while the clear bit is set;
- the absence of a tick on the cycle after a selector change;
- the configuration capture.

Other behaviours can only be shown by the directed scenarios, because they need whole periods counted against a reference:
- the exact 50-cycle and 50,000-cycle spacing;
- the full first period after a selector change or a clear release;
- the ignored count-register writes;
- wrap-around, shown on a narrow second instance.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam int SRC_W   = 8;
    localparam int CFG_W   = 16;
    localparam int CLR_BIT = 8;

    localparam logic [SRC_W-1:0] SRC_NS = 8'd0;
    localparam logic [SRC_W-1:0] SRC_US = 8'd1;
    localparam logic [SRC_W-1:0] SRC_MS = 8'd2;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic             clr;
    } cfg_t;
endpackage

// File: rtl/tsc_cfg_reg.sv
module tsc_cfg_reg
    import tsc_pkg::*;
#(
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] CFG_OFS = 12'h600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg,
    output logic             src_chg
);
    cfg_t cfg_d, cfg_q;
    logic hit;

    always_comb begin
        cfg_d   = cfg_q;
        hit     = wr_en && (addr == CFG_OFS);
        src_chg = 1'b0;
        if (hit) begin
            cfg_d.src = wdata[SRC_W-1:0];
            cfg_d.clr = wdata[CLR_BIT];
            src_chg   = (wdata[SRC_W-1:0] != cfg_q.src);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/tsc_prescaler.sv
module tsc_prescaler
    import tsc_pkg::*;
#(
    parameter int US_DIV = 50,
    parameter int MS_DIV = 50000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src,
    input  logic             clr,
    input  logic             src_chg,
    output logic             tick,
    output logic             ns_mode
);
    localparam int DIV_W = $clog2(MS_DIV + 1);

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] limit;
    logic             valid;

    always_comb begin
        case (src)
            SRC_NS:  limit = DIV_W'(1);
            SRC_US:  limit = DIV_W'(US_DIV);
            SRC_MS:  limit = DIV_W'(MS_DIV);
            default: limit = '0;
        endcase
        valid   = (limit != '0);
        ns_mode = (src == SRC_NS);
        tick    = valid && !clr && (div_q == limit - DIV_W'(1));
        if (clr || src_chg || !valid || tick) div_d = '0;
        else                                  div_d = div_q + DIV_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/tsc_accum.sv
module tsc_accum #(
    parameter int CNT_W   = 32,
    parameter int NS_STEP = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ns_mode,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] step;

    always_comb begin
        step = ns_mode ? CNT_W'(NS_STEP) : CNT_W'(1);
        if (clr)       cnt_d = '0;
        else if (tick) cnt_d = cnt_q + step;
        else           cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/tsc_timestamp.sv
module tsc_timestamp
    import tsc_pkg::*;
#(
    parameter int                ADDR_W  = 12,
    parameter int                DATA_W  = 32,
    parameter int                CNT_W   = 32,
    parameter int                NS_STEP = 20,
    parameter int                US_DIV  = 50,
    parameter int                MS_DIV  = 50000,
    parameter logic [ADDR_W-1:0] CFG_OFS = 12'h600,
    parameter logic [ADDR_W-1:0] CNT_OFS = 12'h602
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [DATA_W-1:0] rdata
);
    cfg_t             cfg;
    logic             src_chg;
    logic             tick;
    logic             ns_mode;
    logic [CNT_W-1:0] cnt;

    tsc_cfg_reg #(.ADDR_W(ADDR_W), .CFG_OFS(CFG_OFS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .cfg(cfg), .src_chg(src_chg)
    );

    tsc_prescaler #(.US_DIV(US_DIV), .MS_DIV(MS_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .src(cfg.src), .clr(cfg.clr),
        .src_chg(src_chg), .tick(tick), .ns_mode(ns_mode)
    );

    tsc_accum #(.CNT_W(CNT_W), .NS_STEP(NS_STEP)) u_acc (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ns_mode(ns_mode),
        .clr(cfg.clr), .cnt(cnt)
    );

    always_comb begin
        rdata = '0;
        if (addr == CFG_OFS) begin
            rdata[SRC_W-1:0] = cfg.src;
            rdata[CLR_BIT]   = cfg.clr;
        end else if (addr == CNT_OFS) begin
            rdata[CNT_W-1:0] = cnt;
        end
    end
endmodule

// File: rtl/tsc_timestamp_chk.sv
module tsc_timestamp_chk
    import tsc_pkg::*;
#(
    parameter int                ADDR_W  = 12,
    parameter int                CNT_W   = 32,
    parameter int                NS_STEP = 20,
    parameter logic [ADDR_W-1:0] CFG_OFS = 12'h600
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [15:0]       wdata,
    input cfg_t              cfg,
    input logic              src_chg,
    input logic              tick,
    input logic [CNT_W-1:0]  cnt
);
    // R4 and R10: nanosecond step of exactly NS_STEP, wrapping modulo 2^CNT_W
    a_r4_ns_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.src == SRC_NS && !cfg.clr) |=> cnt == $past(cnt) + CNT_W'(NS_STEP));

    // R5, R6: the slow timebases never step by more than one
    a_r5_slow_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg.src == SRC_US || cfg.src == SRC_MS) && !cfg.clr)
        |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

    a_r7_invalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.src > SRC_MS && !cfg.clr) |=> $stable(cnt));

    a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.clr |=> cnt == '0);

    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (src_chg && wdata[SRC_W-1:0] != SRC_NS) |=> !tick);

    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CFG_OFS)
        |=> (cfg.src == $past(wdata[SRC_W-1:0]) && cfg.clr == $past(wdata[CLR_BIT])));
endmodule

bind tsc_timestamp tsc_timestamp_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NS_STEP(NS_STEP), .CFG_OFS(CFG_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cfg(cfg), .src_chg(src_chg), .tick(tick), .cnt(cnt)
);

// File: tb/tsc_timestamp_tb.sv
module tsc_timestamp_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] rdata_s;
    int          vecs = 0;
    int          fails = 0;

    localparam logic [11:0] A_CFG = 12'h600;
    localparam logic [11:0] A_CNT = 12'h602;

    always #10 clk = ~clk;

    tsc_timestamp u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata)
    );

    tsc_timestamp #(.CNT_W(12)) u_small (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata_s)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rd(A_CNT, v); chk("R1 count in reset", v, 32'd0);
        rd(A_CFG, v); chk("R1 cfg in reset", v, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        rd(A_CNT, v); chk("R1 first step after reset", v, 32'd20);
    endtask

    task automatic t_ns;
        logic [31:0] c, v;
        rd(A_CNT, c);
        repeat (7) @(negedge clk);
        rd(A_CNT, v); chk("R4 ns step 20/clk", v, c + 32'd140);
    endtask

    task automatic t_us;
        logic [31:0] c, v;
        wr(A_CFG, 16'h0001);
        rd(A_CNT, c);
        repeat (49) @(negedge clk);
        rd(A_CNT, v); chk("R8 no early us tick", v, c);
        @(negedge clk);
        rd(A_CNT, v); chk("R5 us tick at 50", v, c + 32'd1);
        repeat (50) @(negedge clk);
        rd(A_CNT, v); chk("R5 us second tick", v, c + 32'd2);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_ms;
        logic [31:0] c, v;
        wr(A_CFG, 16'h0002);
        rd(A_CNT, c);
        repeat (49999) @(negedge clk);
        rd(A_CNT, v); chk("R8 ms full first period", v, c);
        @(negedge clk);
        rd(A_CNT, v); chk("R6 ms tick at 50000", v, c + 32'd1);
    endtask

    task automatic t_invalid;
        logic [31:0] c, v;
        wr(A_CFG, 16'h0003);
        rd(A_CFG, v); chk("R2 cfg readback 3", v, 32'h3);
        rd(A_CNT, c);
        repeat (100) @(negedge clk);
        rd(A_CNT, v); chk("R7 invalid src holds", v, c);
        wr(A_CNT, 16'hFFFF);
        rd(A_CNT, v); chk("R3 count write ignored", v, c);
        rd(A_CFG, v); chk("R3 cfg untouched by count write", v, 32'h3);
        rd(12'h604, v); chk("R3 unmapped reads zero", v, 32'd0);
    endtask

    task automatic t_ns_again;
        logic [31:0] c, v;
        wr(A_CFG, 16'h0000);
        rd(A_CNT, c);
        repeat (5) @(negedge clk);
        rd(A_CNT, v); chk("R4 ns resumes", v, c + 32'd100);
    endtask

    task automatic t_clear;
        logic [31:0] v;
        wr(A_CFG, 16'h0101);
        @(negedge clk);
        rd(A_CNT, v); chk("R9 cleared", v, 32'd0);
        rd(A_CFG, v); chk("R2 cfg readback clear+src", v, 32'h101);
        repeat (10) @(negedge clk);
        rd(A_CNT, v); chk("R9 held at zero", v, 32'd0);
        wr(A_CFG, 16'h0001);
        rd(A_CNT, v); chk("R9 zero at release", v, 32'd0);
        rd(A_CFG, v); chk("R9 src kept", v, 32'h1);
        repeat (49) @(negedge clk);
        rd(A_CNT, v); chk("R9 full first period", v, 32'd0);
        @(negedge clk);
        rd(A_CNT, v); chk("R9 first tick after release", v, 32'd1);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        wr(A_CFG, 16'h0100);
        repeat (2) @(negedge clk);
        wr(A_CFG, 16'h0000);
        rd(A_CNT, v); chk("R9 zero before wrap run", v, 32'd0);
        repeat (300) @(negedge clk);
        rd(A_CNT, v);  chk("R4 300 ns steps", v, 32'd6000);
        chk("R10 narrow count wraps", rdata_s, 32'd1904);
    endtask

    initial begin
        #(190000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_ns();
        t_us();
        t_ms();
        t_invalid();
        t_ns_again();
        t_clear();
        t_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule